// File: doc/BRIEF.md
# Multichannel Scan Sequencer with Channel Tagging

This block runs slow multichannel acquisition and playback around a 16-way analog multiplexer and a 12-bit converter. A sample tick, produced elsewhere at up to 1 kHz, starts a scan. The scan selects channels 0, 1, ... up to a programmed last channel. For each channel it waits for the multiplexer to settle, starts one conversion, and waits for the converter's done strobe. It then packs the 12-bit result with the 4-bit channel number into a 16-bit word for the buffer.

In the playback direction the block takes 16-bit words. It reads the 4-bit tag and writes the 12-bit value to the one DAC latch that the tag selects. A word whose tag is above the programmed last channel is discarded and counted. The converter itself is modelled only as a start/done handshake.

The scan controller is a four-state machine:
- S_IDLE goes to S_SETTLE on a tick.
- S_SETTLE goes to S_START after SETTLE cycles.
- S_START goes to S_WAIT after one cycle.
- S_WAIT goes on conv_done to S_IDLE if the channel was the last one, and otherwise to S_SETTLE with the next channel.

Top module: `mux_scan_tagger`

## Requirements
- R1: A tick accepted in S_IDLE starts a scan at channel 0. The scan drives mux_sel with each channel number in ascending order and performs exactly one conversion per channel.
- R2: cfg_last holds the number of scanned channels minus one, so 1 to 16 channels can be scanned. The value is captured when the scan starts.
- R3: Each result word is presented as smp_word with smp_valid high for one cycle, in the cycle after conv_done. Bits 15:12 hold the channel number and bits 11:0 hold conv_data.
- R4: conv_start is a single-cycle pulse. It rises SETTLE cycles after mux_sel takes the channel's value, and mux_sel does not change while conv_start is high. For the first channel, conv_start is seen SETTLE+1 cycles after the clock edge that samples the tick.
- R5: A tick that arrives while a scan is in progress does not restart or extend the scan. It sets overrun, which stays high until reset.
- R6: A playback word (out_valid high) whose tag in bits 15:12 is at most cfg_last raises bit [tag] of dac_we for one cycle in the following cycle. In that same cycle dac_data carries bits 11:0 of the word.
- R7: A playback word whose tag exceeds cfg_last raises no dac_we bit. It increments drop_count, which saturates at its maximum.
- R8: After reset, conv_start, smp_valid, overrun, dac_we and drop_count are all zero, and mux_sel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_last | input | 4 | Last channel of the scan (channel count minus one) |
| tick | input | 1 | Sample tick, starts a scan |
| mux_sel | output | 4 | Multiplexer channel select |
| conv_start | output | 1 | Conversion start pulse |
| conv_done | input | 1 | Conversion done strobe |
| conv_data | input | 12 | Conversion result |
| smp_valid | output | 1 | Tagged sample word valid |
| smp_word | output | 16 | Tag in 15:12, sample in 11:0 |
| overrun | output | 1 | Sticky flag: tick during a scan |
| out_valid | input | 1 | Playback word valid |
| out_word | input | 16 | Playback word, tag in 15:12 |
| dac_we | output | 16 | One-hot DAC latch write enables |
| dac_data | output | 12 | Value for the DAC latch |
| drop_count | output | 8 | Saturating count of discarded playback words |

## Verification
The hardest case to reach from the ports is a tick that lands inside a running scan. It has to arrive after the first conversion has started and before the last conversion completes. The stimulus achieves this by forking a second tick from a parallel branch while a four-channel scan is still waiting on the converter model. The scoreboard then confirms that exactly four words still come out, in order, and that overrun stays set through a later clean scan.

// File: rtl/scan_pkg.sv
package scan_pkg;
    localparam int SMP_W  = 12;
    localparam int TAG_W  = 4;
    localparam int WORD_W = SMP_W + TAG_W;
    localparam int NCH    = 1 << TAG_W;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SETTLE,
        S_START,
        S_WAIT
    } scan_state_e;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
    import scan_pkg::*;
#(
    parameter int SETTLE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  cfg_last,
    input  logic              tick,
    output logic [TAG_W-1:0]  mux_sel,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [SMP_W-1:0]  conv_data,
    output logic              smp_valid,
    output logic [WORD_W-1:0] smp_word,
    output logic              overrun
);
    localparam int CW = $clog2(SETTLE + 1);

    scan_state_e      state_q, state_d;
    logic [TAG_W-1:0] ch_q, last_q;
    logic [CW-1:0]    cnt_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (tick) state_d = S_SETTLE;
            S_SETTLE: if (cnt_q == CW'(SETTLE - 1)) state_d = S_START;
            S_START:  state_d = S_WAIT;
            S_WAIT:   if (conv_done) state_d = (ch_q == last_q) ? S_IDLE : S_SETTLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q      <= '0;
            last_q    <= '0;
            cnt_q     <= '0;
            smp_valid <= 1'b0;
            smp_word  <= '0;
            overrun   <= 1'b0;
        end else begin
            smp_valid <= 1'b0;
            if (tick && state_q != S_IDLE) overrun <= 1'b1;
            unique case (state_q)
                S_IDLE: if (tick) begin
                    ch_q   <= '0;
                    last_q <= cfg_last;
                    cnt_q  <= '0;
                end
                S_SETTLE: cnt_q <= cnt_q + 1'b1;
                S_START:  ;
                S_WAIT: if (conv_done) begin
                    smp_valid <= 1'b1;
                    smp_word  <= {ch_q, conv_data};
                    if (ch_q != last_q) begin
                        ch_q  <= ch_q + 1'b1;
                        cnt_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign mux_sel    = ch_q;
    assign conv_start = (state_q == S_START);

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R4
    AST_MUX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> $stable(mux_sel)); // R4
    AST_SCAN_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && tick) |=> (mux_sel == '0)); // R1
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R5
endmodule

// File: rtl/dac_router.sv
module dac_router
    import scan_pkg::*;
#(
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  cfg_last,
    input  logic              out_valid,
    input  logic [WORD_W-1:0] out_word,
    output logic [NCH-1:0]    dac_we,
    output logic [SMP_W-1:0]  dac_data,
    output logic [DROP_W-1:0] drop_count
);
    logic [TAG_W-1:0] tag;
    logic             keep;

    assign tag  = out_word[WORD_W-1:SMP_W];
    assign keep = (tag <= cfg_last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_we     <= '0;
            dac_data   <= '0;
            drop_count <= '0;
        end else begin
            dac_we <= '0;
            if (out_valid) begin
                if (keep) begin
                    dac_we[tag] <= 1'b1;
                    dac_data    <= out_word[SMP_W-1:0];
                end else if (drop_count != '1) begin
                    drop_count <= drop_count + 1'b1;
                end
            end
        end
    end

    AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dac_we)); // R6
    AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && tag > cfg_last) |=> (dac_we == '0)); // R7
endmodule

// File: rtl/mux_scan_tagger.sv
module mux_scan_tagger
    import scan_pkg::*;
#(
    parameter int SETTLE = 8,
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cfg_last,
    input  logic              tick,
    output logic [3:0]        mux_sel,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [11:0]       conv_data,
    output logic              smp_valid,
    output logic [15:0]       smp_word,
    output logic              overrun,
    input  logic              out_valid,
    input  logic [15:0]       out_word,
    output logic [15:0]       dac_we,
    output logic [11:0]       dac_data,
    output logic [DROP_W-1:0] drop_count
);
    scan_ctrl #(.SETTLE(SETTLE)) u_scan (
        .clk(clk), .rst_n(rst_n), .cfg_last(cfg_last), .tick(tick),
        .mux_sel(mux_sel), .conv_start(conv_start), .conv_done(conv_done),
        .conv_data(conv_data), .smp_valid(smp_valid), .smp_word(smp_word),
        .overrun(overrun)
    );

    dac_router #(.DROP_W(DROP_W)) u_route (
        .clk(clk), .rst_n(rst_n), .cfg_last(cfg_last), .out_valid(out_valid),
        .out_word(out_word), .dac_we(dac_we), .dac_data(dac_data),
        .drop_count(drop_count)
    );

    AST_NO_SAMPLE_AT_RESET: assert property (@(posedge clk)
        !rst_n |=> !smp_valid); // R8
endmodule

// File: tb/tb_mux_scan_tagger.sv
module tb_mux_scan_tagger;
    localparam int SETTLE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_last = '0;
    logic        tick = 1'b0;
    logic [3:0]  mux_sel;
    logic        conv_start;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic        smp_valid;
    logic [15:0] smp_word;
    logic        overrun;
    logic        out_valid = 1'b0;
    logic [15:0] out_word = '0;
    logic [15:0] dac_we;
    logic [11:0] dac_data;
    logic [7:0]  drop_count;

    int errors = 0;
    int checks = 0;
    int scan_id = 0;
    logic [15:0] exp_q[$];
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    mux_scan_tagger #(.SETTLE(SETTLE)) dut (.*);

    function automatic logic [11:0] sample_of(int sid, int ch);
        return 12'((sid * 16 + ch) * 37 + 5);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Converter model
    initial forever begin
        @(negedge clk);
        if (conv_start) begin
            automatic int ch = int'(mux_sel);
            repeat (3) @(negedge clk);
            conv_data = sample_of(scan_id, ch);
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
        end
    end

    // Monitor / scoreboard
    initial forever begin
        @(negedge clk);
        if (rst_n && smp_valid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected word", 32'(smp_word), 32'hFFFF_FFFF);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                check("R3 tag", 32'(smp_word[15:12]), 32'(e[15:12]));
                check("R1/R2 word", 32'(smp_word), 32'(e));
            end
        end
    end

    task automatic run_scan(logic [3:0] last);
        int k;
        scan_id++;
        cfg_last = last;
        for (int c = 0; c <= int'(last); c++)
            exp_q.push_back({4'(c), sample_of(scan_id, c)});
        @(negedge clk);
        tick = 1'b1;
        @(posedge clk);
        #1 tick = 1'b0;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!conv_start && k < 100);
        check("R4 settle delay", 32'(k), 32'(SETTLE + 1));
        check("R1 first channel", 32'(mux_sel), 32'd0);
        while (exp_q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic play(logic [15:0] w, logic [15:0] exp_we, string req);
        @(negedge clk);
        out_valid = 1'b1;
        out_word  = w;
        @(negedge clk);
        out_valid = 1'b0;
        check(req, 32'(dac_we), 32'(exp_we));
        if (exp_we != 0) check(req, 32'(dac_data), 32'(w[11:0]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 conv_start", 32'(conv_start), 0);
        check("R8 smp_valid", 32'(smp_valid), 0);
        check("R8 overrun", 32'(overrun), 0);
        check("R8 dac_we", 32'(dac_we), 0);
        check("R8 drop_count", 32'(drop_count), 0);
        check("R8 mux_sel", 32'(mux_sel), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_scan(4'd3);   // R1, R2: four channels
        run_scan(4'd0);   // R2: single channel
        run_scan(4'd15);  // R2: full sixteen
        check("R5 no overrun yet", 32'(overrun), 0);

        // R5: tick inside a running scan
        fork
            run_scan(4'd3);
            begin
                repeat (30) @(negedge clk);
                tick = 1'b1;
                @(negedge clk);
                tick = 1'b0;
            end
        join
        check("R5 overrun set", 32'(overrun), 1);
        check("R5 no extra words", 32'(exp_q.size()), 0);
        run_scan(4'd1);
        check("R5 overrun sticky", 32'(overrun), 1);

        // Playback
        cfg_last = 4'd3;
        play(16'h2ABC, 16'h0004, "R6 tag 2");
        play(16'h3123, 16'h0008, "R6 tag at last");
        play(16'h0FFF, 16'h0001, "R6 tag 0");
        play(16'h4555, 16'h0000, "R7 tag above last");
        check("R7 drop count", 32'(drop_count), 1);
        cfg_last = 4'd15;
        play(16'hF7E1, 16'h8000, "R6 tag 15");
        cfg_last = 4'd0;
        play(16'h1001, 16'h0000, "R7 tag 1 with one channel");
        play(16'hF001, 16'h0000, "R7 tag 15 with one channel");
        check("R7 drop count", 32'(drop_count), 3);
        for (int i = 0; i < 260; i++) begin
            @(negedge clk);
            out_valid = 1'b1;
            out_word  = 16'h5000;
        end
        @(negedge clk);
        out_valid = 1'b0;
        @(negedge clk);
        check("R7 saturation", 32'(drop_count), 32'd255);

        done_flag = 1;
    end

    // Watchdog and summary
    initial begin
        for (int i = 0; i < 150000 && !done_flag; i++) @(negedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule